// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block turns a watchdog expiry into a timed pulse on an external reset pad. A one-cycle expiry strobe starts the pulse, but only while the external output is enabled. The pulse lasts a programmable number of microsecond ticks and then ends. The pad is described as a level plus an output-enable, so the surrounding pad ring can model either a push-pull driver or an open-drain driver.

One 32-bit configuration word controls the pulse. A generation-dependent low field holds the pulse length, and the two top bits hold the pad polarity and the drive type. Those two bits never follow plain data. They move only when a write carries one of four key bytes in bits 31:24, and only in the newer generation, which the parameter `NEWGEN` selects. Every write replaces the length field and keeps everything else. The countdown that produces the expiry and the bus decode that leads to the write strobe sit outside this block.

Top module: `wdt_rst_pulse`

## Requirements
- R1: After a synchronous reset the configuration word reads 0x000000FF, no pulse is active, and the pad is idle: active-low open-drain, so enable is 0 and level is 0.
- R2: A write replaces only the length field, which is bits 19:0 when NEWGEN=1 and bits 7:0 when NEWGEN=0. Every other stored bit keeps its value, and bits outside the length field and bits 31:30 are never set.
- R3: When NEWGEN=1, a written top byte (bits 31:24) of 0xA5 sets bit 31 (active-high pad) and 0x5A clears it. 0xA8 sets bit 30 (push-pull) and 0x8A clears it. Any other top byte, zero or not, leaves bits 31:30 unchanged.
- R4: When NEWGEN=0 the key bytes have no effect, and bits 31:30 stay 0.
- R5: The read port always returns the whole stored word, including bits 31:30, one cycle after a write.
- R6: An expiry strobe seen while idle with the external enable high starts the pulse on the next cycle. The pulse length L is the length field at that moment. The pulse stays asserted for exactly L+1 microsecond ticks and is released on the cycle after the last of them.
- R7: An expiry strobe with the external enable low does not start a pulse.
- R8: An expiry strobe that arrives during a pulse neither restarts nor extends it.
- R9: In push-pull mode (bit 30 = 1) the enable is always 1. The level equals bit 31 while asserted and its inverse while idle.
- R10: In open-drain mode (bit 30 = 0) the level is always 0. With bit 31 = 0 the enable is 1 only while asserted. With bit 31 = 1 the enable is 1 only while idle, so assertion releases the pad and lets it rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| expire_i | input | 1 | One-cycle watchdog expiry strobe |
| ext_out_en_i | input | 1 | Allows expiry to drive the external pad |
| us_tick_i | input | 1 | One-cycle microsecond tick |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Stored configuration word |
| rst_pin_o | output | 1 | Pad level |
| rst_pin_oe_o | output | 1 | Pad output-enable |

## Verification
A corrupted polarity or drive bit appears at the pad outputs in the same cycle, and it appears even while no pulse is active, because the idle level and the enable both depend on those bits. A wrong length counter or pulse state shows up only as a pulse that ends on the wrong tick, so it can lag by up to a full pulse length. A stray bit in the stored word appears on the read port one cycle after the write that caused it. The bench therefore compares the word and both pad outputs against a reference model on every cycle, and it counts ticks during each pulse.

// File: rtl/wdtp_pkg.sv
package wdtp_pkg;

    localparam int REG_W   = 32;
    localparam int POL_BIT = 31;
    localparam int DRV_BIT = 30;

    localparam logic [7:0] KEY_ACT_HIGH   = 8'hA5;
    localparam logic [7:0] KEY_ACT_LOW    = 8'h5A;
    localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
    localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

    localparam logic [REG_W-1:0] CFG_RESET = 32'h0000_00FF;

    typedef enum logic [2:0] {
        KA_NONE,
        KA_SET_POL,
        KA_CLR_POL,
        KA_SET_DRV,
        KA_CLR_DRV
    } key_act_e;

    typedef struct packed {
        logic level;
        logic enable;
    } pad_drive_t;

    function automatic int len_bits(input bit newgen);
        return newgen ? 20 : 8;
    endfunction

    function automatic logic [REG_W-1:0] len_mask(input bit newgen);
        return newgen ? 32'h000F_FFFF : 32'h0000_00FF;
    endfunction

    function automatic key_act_e decode_key(input logic [7:0] top);
        key_act_e k;
        case (top)
            KEY_ACT_HIGH:   k = KA_SET_POL;
            KEY_ACT_LOW:    k = KA_CLR_POL;
            KEY_PUSH_PULL:  k = KA_SET_DRV;
            KEY_OPEN_DRAIN: k = KA_CLR_DRV;
            default:        k = KA_NONE;
        endcase
        return k;
    endfunction

    function automatic pad_drive_t map_pad(input logic asserted,
                                           input logic act_high,
                                           input logic push_pull);
        pad_drive_t d;
        if (push_pull) begin
            d.enable = 1'b1;
            d.level  = asserted ? act_high : ~act_high;
        end else begin
            d.level  = 1'b0;
            d.enable = act_high ? ~asserted : asserted;
        end
        return d;
    endfunction

endpackage

// File: rtl/wdtp_cfg_reg.sv
module wdtp_cfg_reg
    import wdtp_pkg::*;
#(
    parameter bit NEWGEN = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] cfg_o
);
    localparam logic [REG_W-1:0] WMASK = len_mask(NEWGEN);

    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] flags_d;
    logic [REG_W-1:0] cfg_d;
    key_act_e         key;

    generate
        if (NEWGEN) begin : g_keys
            assign key = decode_key(wr_data_i[REG_W-1:REG_W-8]);
        end else begin : g_nokeys
            assign key = KA_NONE;
        end
    endgenerate

    always_comb begin
        flags_d = cfg_q;
        case (key)
            KA_SET_POL: flags_d[POL_BIT] = 1'b1;
            KA_CLR_POL: flags_d[POL_BIT] = 1'b0;
            KA_SET_DRV: flags_d[DRV_BIT] = 1'b1;
            KA_CLR_DRV: flags_d[DRV_BIT] = 1'b0;
            default:    ;
        endcase
        cfg_d = (flags_d & ~WMASK) | (wr_data_i & WMASK);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en_i) begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/wdtp_pulse_timer.sv
module wdtp_pulse_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o
);
    logic [CNT_W-1:0] remain_q;
    logic             active_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_q <= 1'b0;
            remain_q <= '0;
        end else if (active_q) begin
            if (tick_i) begin
                if (remain_q == '0) begin
                    active_q <= 1'b0;
                end else begin
                    remain_q <= remain_q - 1'b1;
                end
            end
        end else if (start_i) begin
            active_q <= 1'b1;
            remain_q <= len_i;
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/wdtp_pad_ctrl.sv
module wdtp_pad_ctrl
    import wdtp_pkg::*;
(
    input  logic asserted_i,
    input  logic act_high_i,
    input  logic push_pull_i,
    output logic level_o,
    output logic enable_o
);
    pad_drive_t drive;

    always_comb begin
        drive = map_pad(asserted_i, act_high_i, push_pull_i);
    end

    assign level_o  = drive.level;
    assign enable_o = drive.enable;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse
    import wdtp_pkg::*;
#(
    parameter bit NEWGEN = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        expire_i,
    input  logic        ext_out_en_i,
    input  logic        us_tick_i,
    input  logic        cfg_wr_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o,
    output logic        rst_pin_o,
    output logic        rst_pin_oe_o
);
    localparam int CNT_W = len_bits(NEWGEN);

    logic [REG_W-1:0] cfg;
    logic             pulse_active;
    logic             pulse_start;

    wdtp_cfg_reg #(.NEWGEN(NEWGEN)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (cfg_wr_i),
        .wr_data_i (cfg_wdata_i),
        .cfg_o     (cfg)
    );

    assign pulse_start = expire_i & ext_out_en_i & ~pulse_active;

    wdtp_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (pulse_start),
        .tick_i   (us_tick_i),
        .len_i    (cfg[CNT_W-1:0]),
        .active_o (pulse_active)
    );

    wdtp_pad_ctrl u_pad (
        .asserted_i  (pulse_active),
        .act_high_i  (cfg[POL_BIT]),
        .push_pull_i (cfg[DRV_BIT]),
        .level_o     (rst_pin_o),
        .enable_o    (rst_pin_oe_o)
    );

    assign cfg_rdata_o = cfg;
endmodule

// File: rtl/wdtp_chk.sv
module wdtp_chk
    import wdtp_pkg::*;
#(
    parameter bit NEWGEN = 1'b1
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        expire_i,
    input logic        ext_en_i,
    input logic        tick_i,
    input logic        wr_i,
    input logic [31:0] wdata_i,
    input logic [31:0] cfg_i,
    input logic        active_i,
    input logic        pin_i,
    input logic        oe_i
);
    localparam logic [31:0] WMASK = len_mask(NEWGEN);
    localparam logic [31:0] KEEP  = WMASK | (NEWGEN ? 32'hC000_0000 : 32'h0);

    assert_reset_value_R1: assert property (@(posedge clk_i)
        rst_i |=> (cfg_i == CFG_RESET) && !active_i);

    assert_spare_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_i & ~KEEP) == 32'h0);

    assert_len_written_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |=> (cfg_i & WMASK) == ($past(wdata_i) & WMASK));

    assert_key_high_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (NEWGEN && wr_i && wdata_i[31:24] == KEY_ACT_HIGH) |=> cfg_i[POL_BIT]);

    assert_key_low_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (NEWGEN && wr_i && wdata_i[31:24] == KEY_ACT_LOW) |=> !cfg_i[POL_BIT]);

    assert_old_nokeys_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !NEWGEN |-> cfg_i[31:30] == 2'b00);

    assert_start_cause_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(active_i) |-> $past(expire_i && ext_en_i));

    assert_disabled_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!active_i && expire_i && !ext_en_i) |=> !active_i);

    assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_i && !tick_i) |=> active_i);

    assert_push_pull_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_i[DRV_BIT] |-> oe_i);

    assert_open_drain_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_i[DRV_BIT] |-> !pin_i);
endmodule

bind wdt_rst_pulse wdtp_chk #(.NEWGEN(NEWGEN)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .expire_i (expire_i),
    .ext_en_i (ext_out_en_i),
    .tick_i   (us_tick_i),
    .wr_i     (cfg_wr_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_i    (cfg_rdata_o),
    .active_i (pulse_active),
    .pin_i    (rst_pin_o),
    .oe_i     (rst_pin_oe_o)
);

// File: tb/sim_wdt_rst_pulse.sv
module sim_wdt_rst_pulse;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic        ext_en = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rd0, rd1;
    logic        pin0, oe0, pin1, oe1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int hi_ticks = 0;
    bit started = 0;

    logic [31:0] m_cfg [2];
    logic        m_act [2];
    int          m_cnt [2];
    logic [31:0] mo, mm, mn;

    always #4 clk = ~clk;

    wdt_rst_pulse #(.NEWGEN(1'b1)) u0 (
        .clk_i(clk), .rst_i(rst), .expire_i(trig), .ext_out_en_i(ext_en),
        .us_tick_i(tick), .cfg_wr_i(we), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rd0), .rst_pin_o(pin0), .rst_pin_oe_o(oe0));

    wdt_rst_pulse #(.NEWGEN(1'b0)) u1 (
        .clk_i(clk), .rst_i(rst), .expire_i(trig), .ext_out_en_i(ext_en),
        .us_tick_i(tick), .cfg_wr_i(we), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rd1), .rst_pin_o(pin1), .rst_pin_oe_o(oe1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model: behavioural state per generation (index 0 new, 1 old)
    always @(posedge clk) begin
        started = 1;
        for (int g = 0; g < 2; g++) begin
            mo = m_cfg[g];
            if (rst) begin
                m_cfg[g] = 32'h0000_00FF;
                m_act[g] = 1'b0;
                m_cnt[g] = 0;
            end else begin
                if (m_act[g]) begin
                    if (tick) begin
                        if (m_cnt[g] == 0) m_act[g] = 1'b0;
                        else m_cnt[g] = m_cnt[g] - 1;
                    end
                end else if (trig && ext_en) begin
                    m_act[g] = 1'b1;
                    m_cnt[g] = int'(g == 0 ? (mo & 32'h000F_FFFF) : (mo & 32'h0000_00FF));
                end
                if (we) begin
                    mn = mo;
                    if (g == 0) begin
                        if (wdata[31:24] == 8'hA5) mn[31] = 1'b1;
                        else if (wdata[31:24] == 8'h5A) mn[31] = 1'b0;
                        else if (wdata[31:24] == 8'hA8) mn[30] = 1'b1;
                        else if (wdata[31:24] == 8'h8A) mn[30] = 1'b0;
                    end
                    mm = (g == 0) ? 32'h000F_FFFF : 32'h0000_00FF;
                    m_cfg[g] = (mn & ~mm) | (wdata & mm);
                end
            end
        end
    end

    // per-cycle comparison, away from both clock edges
    always @(negedge clk) begin
        #2;
        if (started) begin
            for (int g = 0; g < 2; g++) begin
                logic a, pol, pp, epin, eoe, gpin, goe;
                logic [31:0] grd;
                a = m_act[g]; pol = m_cfg[g][31]; pp = m_cfg[g][30];
                if (pp) begin eoe = 1'b1; epin = pol ? a : ~a; end
                else begin epin = 1'b0; eoe = pol ? ~a : a; end
                grd  = (g == 0) ? rd0 : rd1;
                gpin = (g == 0) ? pin0 : pin1;
                goe  = (g == 0) ? oe0 : oe1;
                chk($sformatf("R5 model cfg u%0d", g), grd, m_cfg[g]);
                chk($sformatf("%s model pin u%0d", pp ? "R9" : "R10", g), {31'b0, gpin}, {31'b0, epin});
                chk($sformatf("%s model oe u%0d", pp ? "R9" : "R10", g), {31'b0, goe}, {31'b0, eoe});
            end
            if (pin0 && oe0 && rd0[31:30] == 2'b11 && tick) hi_ticks++;
        end
    end

    always @(negedge clk) begin
        cyc++;
        tick = ((cyc % 4) == 3);
    end

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk); we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0; wdata = 32'h0;
    endtask

    task automatic fire(input logic en);
        @(negedge clk); trig = 1'b1; ext_en = en;
        @(negedge clk); trig = 1'b0; ext_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg u0", rd0, 32'h0000_00FF);
        chk("R1 cfg u1", rd1, 32'h0000_00FF);
        chk("R1 pad u0", {30'b0, pin0, oe0}, 32'h0);

        // R2 length field only, other-key top byte ignored
        write_cfg(32'h3FF2_3456);
        chk("R2 cfg u0", rd0, 32'h0002_3456);
        chk("R2 cfg u1", rd1, 32'h0000_0056);

        // R3 / R4 key bytes
        write_cfg(32'hA500_0003);
        chk("R3 active-high key u0", rd0, 32'h8000_0003);
        chk("R4 keys ignored u1", rd1, 32'h0000_0003);
        write_cfg(32'hA800_0004);
        chk("R3 push-pull key u0", rd0, 32'hC000_0004);
        write_cfg(32'h7700_0004);
        chk("R3 other key u0", rd0, 32'hC000_0004);
        chk("R4 old gen u1", rd1, 32'h0000_0004);

        // R7 expiry with output disabled
        hi_ticks = 0;
        fire(1'b0);
        repeat (10) @(negedge clk);
        chk("R7 no pulse pin", {31'b0, pin0}, 32'h0);
        chk("R7 no pulse ticks", hi_ticks, 0);

        // R6 pulse of L+1 ticks, L=4
        hi_ticks = 0;
        fire(1'b1);
        chk("R6 pulse started", {31'b0, pin0}, 32'h1);
        repeat (40) @(negedge clk);
        chk("R6 tick count", hi_ticks, 5);
        chk("R6 released", {31'b0, pin0}, 32'h0);

        // R8 retrigger mid-pulse
        hi_ticks = 0;
        fire(1'b1);
        repeat (6) @(negedge clk);
        fire(1'b1);
        repeat (40) @(negedge clk);
        chk("R8 tick count after retrigger", hi_ticks, 5);
        chk("R8 released", {31'b0, pin0}, 32'h0);

        // R9 push-pull active-low
        write_cfg(32'h5A00_0002);
        chk("R9 idle pp low", {30'b0, pin0, oe0}, 32'h3);
        fire(1'b1);
        chk("R9 asserted pp low", {30'b0, pin0, oe0}, 32'h1);
        repeat (30) @(negedge clk);

        // R10 open-drain active-low then active-high
        write_cfg(32'h8A00_0002);
        chk("R10 idle od low", {30'b0, pin0, oe0}, 32'h0);
        fire(1'b1);
        chk("R10 asserted od low", {30'b0, pin0, oe0}, 32'h1);
        repeat (30) @(negedge clk);
        write_cfg(32'hA500_0002);
        chk("R10 idle od high", {30'b0, pin0, oe0}, 32'h1);
        fire(1'b1);
        chk("R10 asserted od high", {30'b0, pin0, oe0}, 32'h0);
        repeat (30) @(negedge clk);
        chk("R10 released od high", {30'b0, pin0, oe0}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule